// File: doc/BRIEF.md
# Four-Register Byte-Code Engine

This block is a compact multi-cycle processor that runs a byte-coded program held in an external, byte-wide program memory. Each instruction starts with one byte: the high nibble selects one of sixteen operations, the low nibble names a destination and a source among four 8-bit registers. Some operations carry extra bytes: an immediate value, or a 16-bit absolute branch target. The core keeps a zero flag, a 16-bit instruction pointer and a 16-bit string pointer. The string pointer moves up after a store through it and down after a load through it.

A host pulses `start` while the core is idle. The core then clears its registers, flag and pointers and fetches from address 0. It continues until it executes the check operation. That operation joins the four registers into one 32-bit word, with register 0 as the least significant byte, and compares it against a fixed magic constant. The core then raises `done` for one cycle, holds the result on `pass` and goes idle. Both memory ports are synchronous: read data arrives on the cycle after the read strobe.

The controller walks through these states:
- `ST_IDLE`: waits for start.
- `ST_FETCH`: reads the opcode byte.
- `ST_DECODE`: executes single-byte operations and issues data accesses.
- `ST_ARG`: reads the first operand byte.
- `ST_IMM`: writes an immediate value.
- `ST_TLO` and `ST_THI`: collect the low and high target bytes.
- `ST_MEMWB`: writes loaded data back.
- `ST_DONE`: the one-cycle finish state.

The transitions are:
- IDLE to FETCH on start.
- FETCH to DECODE always.
- DECODE to ARG for the immediate and branch opcodes.
- DECODE to MEMWB for the two loads.
- DECODE to DONE for the check opcode.
- DECODE to FETCH for all other opcodes.
- ARG to IMM for the immediate opcode, otherwise ARG to TLO.
- TLO to THI, then THI, IMM and MEMWB each back to FETCH.
- DONE to IDLE.

Top module: `bytevm_core`

## Requirements
- R1: After reset, and until `start` is seen in idle, `prog_rd`, `dmem_rd`, `dmem_wr`, `done` and `pass` are all 0.
- R2: An instruction byte carries the opcode in bits 7..4, the destination register in bits 3..2 and the source register in bits 1..0. Opcode 0x0 copies the source register into the destination register. A start clears all four registers to 0.
- R3: Opcode 0x1 loads the byte that follows it into the destination register, and execution resumes two bytes after the opcode.
- R4: Opcode 0x2 loads the data byte at address zero-extended(source register) into the destination register. Opcode 0x3 writes the source register to address zero-extended(destination register). A read and a write are never issued in the same cycle.
- R5: Opcodes 0x4 and 0x5 change no register.
- R6: Opcode 0x6 XORs the source register into the destination register. Opcode 0xD adds 1 to the destination register and opcode 0xE subtracts 1 from it, both modulo 256.
- R7: Opcode 0x7 sets the zero flag when the destination register equals the source register and clears it otherwise. It leaves every register unchanged.
- R8: Opcodes 0x8 (branch if zero set), 0x9 (branch if zero clear) and 0xA (always branch) take a 16-bit absolute target from the next two bytes, low byte first. When the branch is not taken, execution resumes three bytes after the opcode.
- R9: Opcode 0xB writes the destination register at the string pointer, then adds 1 to the pointer. Opcode 0xC loads the byte at the string pointer into the destination register, then subtracts 1 from the pointer. A start sets the pointer to `SP_INIT` (default 0), and the pointer wraps at 16 bits.
- R10: Opcode 0xF raises `done` for exactly one cycle. It sets `pass` to 1 when {r3,r2,r1,r0} equals 0x01030307 and to 0 otherwise, keeps `pass` until the next start, and issues no further fetch.
- R11: A `start` pulse while a program is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run from address 0 when idle |
| prog_rd | output | 1 | Program memory read strobe |
| prog_addr | output | 16 | Program memory byte address |
| prog_data | input | 8 | Program byte, valid the cycle after `prog_rd` |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |
| dmem_addr | output | 16 | Data memory byte address |
| dmem_wdata | output | 8 | Data memory write byte |
| dmem_rdata | input | 8 | Data memory read byte, valid the cycle after `dmem_rd` |
| done | output | 1 | One-cycle pulse when the check opcode executes |
| pass | output | 1 | Result of the last magic comparison |

## Verification
The arithmetic opcodes are swept over every pair drawn from a set of edge bytes (0x00, 0x01, 0x7F, 0x80, 0xFF, 0x5A). This set separates wrap-around at both ends from ordinary values and separates XOR from a copy. Every destination and source pair of the register copy is run, so a swapped or misplaced field shows up. Each conditional branch is run with equal and unequal compare operands, which separates taken from fall-through paths and checks the byte order of the target. The string pointer is driven below zero and back up through zero, and the magic check gets the correct word, each single-byte corruption and a byte-reversed word, so an error in byte order or in a single lane is caught.

// File: rtl/bytevm_pkg.sv
package bytevm_pkg;

    typedef enum logic [3:0] {
        OP_MOVR = 4'h0,
        OP_MOVI = 4'h1,
        OP_LD   = 4'h2,
        OP_ST   = 4'h3,
        OP_NOPA = 4'h4,
        OP_NOPB = 4'h5,
        OP_XOR  = 4'h6,
        OP_CMP  = 4'h7,
        OP_JZ   = 4'h8,
        OP_JNZ  = 4'h9,
        OP_JMP  = 4'hA,
        OP_STOS = 4'hB,
        OP_SCAS = 4'hC,
        OP_INC  = 4'hD,
        OP_DEC  = 4'hE,
        OP_CHK  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_ARG,
        ST_IMM,
        ST_TLO,
        ST_THI,
        ST_MEMWB,
        ST_DONE
    } state_e;

    typedef struct packed {
        opcode_e    op;
        logic [1:0] dst;
        logic [1:0] src;
    } instr_t;

endpackage

// File: rtl/bytevm_regfile.sv
module bytevm_regfile #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    localparam int IDW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [IDW-1:0]     waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [IDW-1:0]     ra,
    input  logic [IDW-1:0]     rb,
    output logic [DW-1:0]      rda,
    output logic [DW-1:0]      rdb,
    output logic [NREG*DW-1:0] all_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (clr) begin
                q <= '0;
            end else if (we && (waddr == IDW'(g))) begin
                q <= wdata;
            end
        end
        assign all_o[g*DW +: DW] = q;
    end

    assign rda = all_o[ra*DW +: DW];
    assign rdb = all_o[rb*DW +: DW];

endmodule

// File: rtl/bytevm_alu.sv
module bytevm_alu
    import bytevm_pkg::*;
#(
    parameter int DW = 8
) (
    input  opcode_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          wr,
    output logic          z_wr,
    output logic          z_nxt
);

    logic [DW-1:0] diff;
    assign diff = a - b;

    always_comb begin
        res   = a;
        wr    = 1'b0;
        z_wr  = 1'b0;
        z_nxt = 1'b0;
        case (op)
            OP_MOVR: begin res = b;        wr = 1'b1; end
            OP_XOR:  begin res = a ^ b;    wr = 1'b1; end
            OP_INC:  begin res = a + 1'b1; wr = 1'b1; end
            OP_DEC:  begin res = a - 1'b1; wr = 1'b1; end
            OP_CMP:  begin z_wr = 1'b1; z_nxt = (diff == '0); end
            default: ;
        endcase
    end

endmodule

// File: rtl/bytevm_branch.sv
module bytevm_branch
    import bytevm_pkg::*;
(
    input  opcode_e op,
    input  logic    zf,
    output logic    take
);

    always_comb begin
        case (op)
            OP_JZ:   take = zf;
            OP_JNZ:  take = !zf;
            OP_JMP:  take = 1'b1;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bytevm_core.sv
module bytevm_core
    import bytevm_pkg::*;
#(
    parameter int              AW      = 16,
    parameter int              DW      = 8,
    parameter int              NREG    = 4,
    parameter logic [31:0]     MAGIC   = 32'h0103_0307,
    parameter logic [AW-1:0]   SP_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          prog_rd,
    output logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    output logic          dmem_rd,
    output logic          dmem_wr,
    output logic [AW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    input  logic [DW-1:0] dmem_rdata,
    output logic          done,
    output logic          pass
);

    localparam int IDW = $clog2(NREG);
    localparam int RW  = NREG * DW;

    state_e        state_q, state_d;
    logic [AW-1:0] ip_q, sp_q;
    logic          z_q, pass_q;
    instr_t        ins_q, cur;
    logic [7:0]    tlo_q;

    logic [DW-1:0] dst_val, src_val, alu_res, rf_wdata;
    logic [RW-1:0] regs_all;
    logic          alu_wr, z_wr, z_nxt, take, rf_we, rf_clr, go;

    assign go  = (state_q == ST_IDLE) && start;
    assign cur = (state_q == ST_DECODE) ? instr_t'(prog_data) : ins_q;

    bytevm_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rf_clr),
        .we    (rf_we),
        .waddr (IDW'(cur.dst)),
        .wdata (rf_wdata),
        .ra    (IDW'(cur.dst)),
        .rb    (IDW'(cur.src)),
        .rda   (dst_val),
        .rdb   (src_val),
        .all_o (regs_all)
    );

    bytevm_alu #(.DW(DW)) u_alu (
        .op    (cur.op),
        .a     (dst_val),
        .b     (src_val),
        .res   (alu_res),
        .wr    (alu_wr),
        .z_wr  (z_wr),
        .z_nxt (z_nxt)
    );

    bytevm_branch u_br (
        .op   (ins_q.op),
        .zf   (z_q),
        .take (take)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_FETCH : ST_IDLE;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                case (cur.op)
                    OP_MOVI, OP_JZ, OP_JNZ, OP_JMP: state_d = ST_ARG;
                    OP_LD, OP_SCAS:                 state_d = ST_MEMWB;
                    OP_CHK:                         state_d = ST_DONE;
                    default:                        state_d = ST_FETCH;
                endcase
            end
            ST_ARG:    state_d = (ins_q.op == OP_MOVI) ? ST_IMM : ST_TLO;
            ST_IMM:    state_d = ST_FETCH;
            ST_TLO:    state_d = ST_THI;
            ST_THI:    state_d = ST_FETCH;
            ST_MEMWB:  state_d = ST_FETCH;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and register-file write port
    always_comb begin
        prog_rd    = 1'b0;
        prog_addr  = ip_q;
        dmem_rd    = 1'b0;
        dmem_wr    = 1'b0;
        dmem_addr  = '0;
        dmem_wdata = '0;
        rf_we      = 1'b0;
        rf_wdata   = alu_res;
        rf_clr     = go;
        done       = 1'b0;
        unique case (state_q)
            ST_FETCH, ST_ARG, ST_TLO: prog_rd = 1'b1;
            ST_DECODE: begin
                rf_we = alu_wr;
                case (cur.op)
                    OP_LD: begin
                        dmem_rd   = 1'b1;
                        dmem_addr = AW'(src_val);
                    end
                    OP_ST: begin
                        dmem_wr    = 1'b1;
                        dmem_addr  = AW'(dst_val);
                        dmem_wdata = src_val;
                    end
                    OP_STOS: begin
                        dmem_wr    = 1'b1;
                        dmem_addr  = sp_q;
                        dmem_wdata = dst_val;
                    end
                    OP_SCAS: begin
                        dmem_rd   = 1'b1;
                        dmem_addr = sp_q;
                    end
                    default: ;
                endcase
            end
            ST_IMM: begin
                rf_we    = 1'b1;
                rf_wdata = DW'(prog_data);
            end
            ST_MEMWB: begin
                rf_we    = 1'b1;
                rf_wdata = dmem_rdata;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign pass = pass_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_q   <= '0;
            sp_q   <= SP_INIT;
            z_q    <= 1'b0;
            ins_q  <= '0;
            tlo_q  <= '0;
            pass_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ip_q   <= '0;
                        sp_q   <= SP_INIT;
                        z_q    <= 1'b0;
                        pass_q <= 1'b0;
                    end
                end
                ST_FETCH, ST_ARG: ip_q <= ip_q + 1'b1;
                ST_DECODE: begin
                    ins_q <= cur;
                    if (z_wr) z_q <= z_nxt;
                    if (cur.op == OP_STOS) sp_q <= sp_q + 1'b1;
                    if (cur.op == OP_SCAS) sp_q <= sp_q - 1'b1;
                    if (cur.op == OP_CHK)  pass_q <= (regs_all == RW'(MAGIC));
                end
                ST_TLO: begin
                    tlo_q <= prog_data;
                    ip_q  <= ip_q + 1'b1;
                end
                ST_THI: begin
                    if (take) ip_q <= AW'({prog_data, tlo_q});
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bytevm_chk.sv
module bytevm_chk
    import bytevm_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_rd,
    input logic          dmem_rd,
    input logic          dmem_wr,
    input logic          done,
    input state_e        state,
    input opcode_e       op,
    input logic [AW-1:0] ip,
    input logic [AW-1:0] sp,
    input logic [RW-1:0] regs
);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_fetch_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !prog_rd);

    p_mem_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd && dmem_wr));

    p_ip_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (ip == $past(ip) + 1'b1));

    p_sp_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && op == OP_STOS) |=> (sp == $past(sp) + 1'b1));

    p_sp_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && op == OP_SCAS) |=> (sp == $past(sp) - 1'b1));

    p_cmp_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && op == OP_CMP) |=> $stable(regs));

endmodule

bind bytevm_core bytevm_chk #(.AW(AW), .RW(NREG*DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_rd (prog_rd),
    .dmem_rd (dmem_rd),
    .dmem_wr (dmem_wr),
    .done    (done),
    .state   (state_q),
    .op      (cur.op),
    .ip      (ip_q),
    .sp      (sp_q),
    .regs    (regs_all)
);

// File: tb/bytevm_core_tb.sv
module bytevm_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prog_rd, dmem_rd, dmem_wr, done, pass;
    logic [15:0] prog_addr, dmem_addr;
    logic [7:0]  prog_data, dmem_wdata, dmem_rdata;

    always #4 clk = ~clk;

    bytevm_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prog_rd(prog_rd), .prog_addr(prog_addr), .prog_data(prog_data),
        .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .done(done), .pass(pass)
    );

    logic [7:0]  pmem [256];
    logic [7:0]  dmem [256];
    logic [15:0] wl_addr [32];
    logic [7:0]  wl_data [32];
    int          wcnt, done_cnt, quiet_rd, pc;
    int          checks = 0, fails = 0;
    bit          watch = 1'b0, finished = 1'b0;

    always @(posedge clk) begin
        if (prog_rd) prog_data <= pmem[prog_addr[7:0]];
        if (dmem_rd) dmem_rdata <= dmem[dmem_addr[7:0]];
        if (dmem_wr) begin
            dmem[dmem_addr[7:0]] <= dmem_wdata;
            if (wcnt < 32) begin
                wl_addr[wcnt] <= dmem_addr;
                wl_data[wcnt] <= dmem_wdata;
            end
            wcnt <= wcnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
        if (watch && prog_rd) quiet_rd <= quiet_rd + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pclear();
        for (int i = 0; i < 256; i++) pmem[i] = 8'hF0;
        pc = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        pmem[pc] = b;
        pc++;
    endtask

    task automatic dump();
        emit(8'hB0); emit(8'hB4); emit(8'hB8); emit(8'hBC);
    endtask

    task automatic run(input int late_start);
        int n;
        @(negedge clk);
        wcnt = 0; done_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            if (late_start != 0 && n == late_start) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL run timeout actual=hung expected=done");
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    logic [7:0] vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
    logic [3:0] aops [5] = '{4'h6, 4'hD, 4'hE, 4'h4, 4'h5};

    initial begin
        logic [7:0] e, a, b;
        logic [7:0] mv [4];
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
        wcnt = 0; done_cnt = 0; quiet_rd = 0;
        repeat (3) @(negedge clk);
        // R1: reset state, and idle without start
        chk("R1 done", done, 0);
        chk("R1 pass", pass, 0);
        chk("R1 prog_rd", prog_rd, 0);
        chk("R1 dmem strobes", {dmem_rd, dmem_wr}, 0);
        rst_n = 1'b1;
        watch = 1'b1;
        repeat (10) @(negedge clk);
        watch = 1'b0;
        chk("R1 no fetch before start", quiet_rd, 0);

        // R2: every destination/source pair of the register copy
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 4; s++) begin
                pclear();
                for (int i = 0; i < 4; i++) begin
                    mv[i] = 8'h21 + 8'(i * 17);
                    emit(8'h10 | 8'(i << 2));   // R3 immediate load
                    emit(mv[i]);
                end
                emit({4'h0, 2'(d), 2'(s)});
                dump();
                run(0);
                for (int i = 0; i < 4; i++) begin
                    e = (i == d) ? mv[s] : mv[i];
                    chk("R2 copy", dmem[i], e);
                end
            end
        end
        chk("R3 immediate stream writes", wcnt, 4);

        // R5 R6: ALU and no-op sweep, destination r1, source r2
        for (int o = 0; o < 5; o++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    a = vals[ia]; b = vals[ib];
                    pclear();
                    emit(8'h14); emit(a);
                    emit(8'h18); emit(b);
                    emit({aops[o], 2'd1, 2'd2});
                    dump();
                    run(0);
                    case (aops[o])
                        4'h6: e = a ^ b;
                        4'hD: e = a + 8'd1;
                        4'hE: e = a - 8'd1;
                        default: e = a;
                    endcase
                    if (aops[o] == 4'h4 || aops[o] == 4'h5) chk("R5 nop keeps reg", dmem[1], e);
                    else chk("R6 alu result", dmem[1], e);
                    chk("R6 source kept", dmem[2], b);
                    chk("R2 start clears r0", dmem[0], 0);
                end
            end
        end

        // R7 R8: compare then conditional branch, little-endian target
        for (int j = 0; j < 2; j++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib += 2) begin
                    a = vals[ia]; b = (ib == 0) ? vals[ia] : vals[ib];
                    pclear();
                    emit(8'h10); emit(a);
                    emit(8'h14); emit(b);
                    emit(8'h71);
                    emit((j == 0) ? 8'h80 : 8'h90); emit(8'd13); emit(8'h00);
                    emit(8'h1C); emit(8'hAA);
                    emit(8'hA0); emit(8'd15); emit(8'h00);
                    emit(8'h1C); emit(8'h55);
                    dump();
                    run(0);
                    e = (((j == 0) && (a == b)) || ((j == 1) && (a != b))) ? 8'h55 : 8'hAA;
                    chk("R8 branch path", dmem[3], e);
                    chk("R7 cmp keeps dst", dmem[0], a);
                    chk("R7 cmp keeps src", dmem[1], b);
                end
            end
        end

        // R4: store through register, load back
        for (int k = 0; k < 3; k++) begin
            a = (k == 0) ? 8'h20 : (k == 1) ? 8'h80 : 8'hFE;
            b = a ^ 8'hA5;
            pclear();
            emit(8'h10); emit(a);
            emit(8'h14); emit(b);
            emit(8'h31);
            emit(8'h28);
            dump();
            run(0);
            chk("R4 store addr", wl_addr[0], {8'h00, a});
            chk("R4 store data", dmem[a], b);
            chk("R4 load value", dmem[2], b);
        end

        // R9: string pointer both directions, wrap through zero
        pclear();
        dmem[1] = 8'h77; dmem[255] = 8'h99;
        emit(8'h10); emit(8'h3C);
        emit(8'hB0); emit(8'hC4); emit(8'hC8); emit(8'hCC);
        emit(8'hB4); emit(8'hB8); emit(8'hBC);
        run(0);
        chk("R9 write count", wcnt, 4);
        chk("R9 first addr", wl_addr[0], 16'h0000);
        chk("R9 wrap down addr", wl_addr[1], 16'hFFFE);
        chk("R9 scas r1", wl_data[1], 8'h77);
        chk("R9 addr FFFF", wl_addr[2], 16'hFFFF);
        chk("R9 scas r2", wl_data[2], 8'h3C);
        chk("R9 wrap up addr", wl_addr[3], 16'h0000);
        chk("R9 scas r3", wl_data[3], 8'h99);

        // R10: magic compare, done pulse, halt
        for (int v = 0; v < 7; v++) begin
            logic [31:0] w;
            w = 32'h0103_0307;
            if (v >= 1 && v <= 4) w = w + (32'h1 << (8 * (v - 1)));
            if (v == 5) w = 32'h0;
            if (v == 6) w = 32'h0703_0301;
            pclear();
            for (int i = 0; i < 4; i++) begin
                emit(8'h10 | 8'(i << 2));
                emit(w[8*i +: 8]);
            end
            emit(8'hF0);
            run(0);
            chk("R10 done one cycle", done_cnt, 1);
            chk("R10 pass", pass, (w == 32'h0103_0307) ? 1 : 0);
            quiet_rd = 0; watch = 1'b1;
            repeat (20) @(negedge clk);
            watch = 1'b0;
            chk("R10 halted no fetch", quiet_rd, 0);
            chk("R10 pass held", pass, (w == 32'h0103_0307) ? 1 : 0);
        end

        // R11: start mid-run ignored
        pclear();
        emit(8'h10); emit(8'h42);
        emit(8'hB0);
        for (int i = 0; i < 10; i++) emit(8'h40);
        emit(8'hB0);
        run(8);
        chk("R11 write count", wcnt, 2);
        chk("R11 second addr", wl_addr[1], 16'h0001);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule